// File: doc/BRIEF.md
# XOR-Indexed Carry-Less Multiplier

This block multiplies two 32-bit operands in a ring where addition is XOR and where the partial product `x[i] & y[j]` lands in result bit `i ^ j`. A plain carry-less multiply uses bit `i + j` instead. Put another way, each set bit `k` of the multiplier adds a copy of the multiplicand in which every bit has moved from index `i` to index `i ^ k`, and these copies are XOR-summed. The product is commutative and associative, and it distributes over XOR. Multiplying a value by itself gives that value's parity.

The block is an iterative datapath. It handles one multiplier bit per cycle, using one shared five-stage index-XOR permuter and one accumulator. A caller pulses `start` with the operands while the block is idle. `busy` then stays high for 32 cycles. `done` pulses for one cycle when `result` holds the product, and `result` keeps that value until the next accepted start.

Top module: `xorix_mul_top`

## Requirements
- R1: For every k, `result[k]` after `done` equals the XOR of `x[i] & y[j]` over all pairs (i, j) with `i ^ j == k`, where x and y are the operands that were accepted.
- R2: With y = 1 the result equals x. With y = 0 the result is 0.
- R3: With y = `1 << k`, result bit `i ^ k` equals x bit i for every i.
- R4: Swapping the two operands gives the same result.
- R5: With y equal to x, result bit 0 is the XOR of all bits of x and bits 31..1 are 0. An x with odd popcount therefore gives 1.
- R6: A start seen at a rising edge while idle is accepted and raises `busy`. `done` rises exactly 32 rising edges later, in the same edge where `busy` falls, and stays high for one cycle only.
- R7: `start` and the operand inputs have no effect while `busy` is high.
- R8: After reset, `busy` = 0, `done` = 0 and `result` = 0. While idle with no start, `result` holds its value.
- R9: The product distributes over XOR: `mul(a, b ^ c) == mul(a, b) ^ mul(a, c)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a product; accepted only while idle |
| x | input | 32 | Multiplicand, sampled on the accepting edge |
| y | input | 32 | Multiplier, sampled on the accepting edge |
| busy | output | 1 | High while the 32 steps are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| result | output | 32 | Accumulator; holds the product after `done` |

## Verification
The hardest case to reach is a new request that arrives in the middle of a run. The operand inputs must be sampled only once, and a late `start` must neither restart the step counter nor reload the accumulator. The bench raises `start` with fresh random operands several cycles into a run. It then checks that the result still matches the first operand pair and that the latency is still exactly 32 edges. To cover the algebraic rules, the bench makes paired runs: swapped operands, self-products, single-bit multipliers and XOR-split multipliers. These catch a permuter stage that is wired to the wrong control bit, which would still pass for many single random products.

// File: rtl/xm_pkg.sv
package xm_pkg;
    localparam int unsigned XM_W  = 32;
    localparam int unsigned XM_LW = $clog2(XM_W);

    typedef enum logic {
        XM_IDLE = 1'b0,
        XM_RUN  = 1'b1
    } xm_state_e;

    typedef struct packed {
        logic [XM_W-1:0] mcand;
        logic [XM_W-1:0] mplier;
    } xm_opnd_t;
endpackage

// File: rtl/xm_ctrl.sv
module xm_ctrl #(
    parameter int unsigned W  = xm_pkg::XM_W,
    localparam int unsigned LW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          accept,
    output logic          run,
    output logic          fin,
    output logic [LW-1:0] step
);
    import xm_pkg::*;

    xm_state_e st_q;
    logic      last;

    assign accept = (st_q == XM_IDLE) && start;
    assign run    = (st_q == XM_RUN);
    assign last   = (step == LW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= XM_IDLE;
            step <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st_q)
                XM_IDLE: begin
                    if (accept) begin
                        st_q <= XM_RUN;
                        step <= '0;
                    end
                end
                XM_RUN: begin
                    step <= step + 1'b1;
                    if (last) begin
                        st_q <= XM_IDLE;
                        fin  <= 1'b1;
                    end
                end
                default: st_q <= XM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xm_perm.sv
module xm_perm #(
    parameter int unsigned W  = xm_pkg::XM_W,
    localparam int unsigned LW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [LW-1:0] ctl,
    output logic [W-1:0]  dout
);
    logic [LW:0][W-1:0] stg;

    assign stg[0] = din;

    for (genvar s = 0; s < LW; s++) begin : g_stage
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign stg[s+1][i] = ctl[s] ? stg[s][i ^ (1 << s)] : stg[s][i];
        end
    end

    assign dout = stg[LW];
endmodule

// File: rtl/xm_acc.sv
module xm_acc #(
    parameter int unsigned W  = xm_pkg::XM_W,
    localparam int unsigned LW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            run,
    input  logic [LW-1:0]   step,
    input  xm_pkg::xm_opnd_t opnd_in,
    input  logic [W-1:0]    perm_out,
    output logic [W-1:0]    mcand_q,
    output logic [W-1:0]    acc_q
);
    xm_pkg::xm_opnd_t op_q;

    assign mcand_q = op_q.mcand;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= '0;
            acc_q <= '0;
        end else if (accept) begin
            op_q  <= opnd_in;
            acc_q <= '0;
        end else if (run && op_q.mplier[step]) begin
            acc_q <= acc_q ^ perm_out;
        end
    end
endmodule

// File: rtl/xorix_mul_top.sv
module xorix_mul_top (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] x,
    input  logic [31:0] y,
    output logic        busy,
    output logic        done,
    output logic [31:0] result
);
    import xm_pkg::*;

    logic             accept;
    logic             run;
    logic [XM_LW-1:0] step;
    logic [XM_W-1:0]  mcand_q;
    logic [XM_W-1:0]  perm_out;
    xm_opnd_t         opnd_in;

    assign opnd_in.mcand  = x;
    assign opnd_in.mplier = y;

    xm_ctrl #(.W(XM_W)) ctrl_i (
        .clk(clk), .rst(rst), .start(start),
        .accept(accept), .run(run), .fin(done), .step(step)
    );

    xm_perm #(.W(XM_W)) perm_i (
        .din(mcand_q), .ctl(step), .dout(perm_out)
    );

    xm_acc #(.W(XM_W)) acc_i (
        .clk(clk), .rst(rst), .accept(accept), .run(run), .step(step),
        .opnd_in(opnd_in), .perm_out(perm_out),
        .mcand_q(mcand_q), .acc_q(result)
    );

    assign busy = run;
endmodule

// File: rtl/xorix_mul_chk.sv
module xorix_mul_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] x,
    input logic [31:0] y,
    input logic        busy,
    input logic        done,
    input logic [31:0] result
);
    logic [6:0]  run_len;
    logic [31:0] x_lat;
    logic [31:0] y_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            x_lat   <= '0;
            y_lat   <= '0;
        end else if (start && !busy) begin
            run_len <= '0;
            x_lat   <= x;
            y_lat   <= y;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R6
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst) busy |=> (busy || done)); // R7
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> (run_len == 7'd32)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(result)); // R8
    AST_MUL_ONE: assert property (@(posedge clk) disable iff (rst) (done && y_lat == 32'd1) |-> (result == x_lat)); // R2
    AST_MUL_ZERO: assert property (@(posedge clk) disable iff (rst) (done && y_lat == 32'd0) |-> (result == 32'd0)); // R2
endmodule

bind xorix_mul_top xorix_mul_chk chk_i (.*);

// File: tb/xorix_mul_top_tb_top.sv
module xorix_mul_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] x;
    logic [31:0] y;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xorix_mul_top dut_i (
        .clk(clk), .rst(rst), .start(start), .x(x), .y(y),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                r[i ^ j] ^= a[i] & b[j];
        return r;
    endfunction

    function automatic logic [31:0] ref_perm(input logic [31:0] a, input int k);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) r[i ^ k] = a[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // poke: raise start with other operands mid-run (R7)
    task automatic do_mul(input logic [31:0] a, input logic [31:0] b, input bit poke,
                          output logic [31:0] r);
        int n;
        @(negedge clk);
        start = 1'b1; x = a; y = b;
        @(negedge clk);
        start = 1'b0; x = $urandom; y = $urandom;
        chk("R6 busy after accept", 32'(busy), 32'd1);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) start = 1'b1;
            if (poke && n == 5) start = 1'b0;
            if (!done && !busy) begin
                chk("R6 busy held during run", 32'(busy), 32'd1);
            end
        end
        start = 1'b0;
        chk("R6 latency", 32'(n), 32'd32);
        chk("R6 busy low at done", 32'(busy), 32'd0);
        r = result;
        @(negedge clk);
        chk("R6 done one cycle", 32'(done), 32'd0);
        chk("R8 result held", result, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] a, b, c, r1, r2, r3;
        int k;
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; x = '0; y = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset busy", 32'(busy), 32'd0);
        chk("R8 reset done", 32'(done), 32'd0);
        chk("R8 reset result", result, 32'd0);

        // directed corners
        do_mul(32'hDEADBEEF, 32'd1, 0, r1); chk("R2 times one", r1, 32'hDEADBEEF);
        do_mul(32'hDEADBEEF, 32'd0, 0, r1); chk("R2 times zero", r1, 32'd0);
        do_mul(32'd0, 32'hFFFFFFFF, 0, r1); chk("R2 zero times", r1, 32'd0);
        do_mul(32'h00000007, 32'h00000007, 0, r1); chk("R5 odd self", r1, 32'd1);
        do_mul(32'hFFFFFFFF, 32'hFFFFFFFF, 0, r1); chk("R5 even self", r1, 32'd0);
        do_mul(32'h12345678, 32'h80000000, 0, r1); chk("R3 top bit", r1, ref_perm(32'h12345678, 31));
        do_mul(32'hFFFFFFFF, 32'hFFFFFFFF, 0, r1); chk("R1 all ones", r1, ref_mul(32'hFFFFFFFF, 32'hFFFFFFFF));

        // R7: mid-run start is ignored
        for (int t = 0; t < 4; t++) begin
            a = $urandom; b = $urandom;
            do_mul(a, b, 1, r1);
            chk("R7 start ignored while busy", r1, ref_mul(a, b));
        end

        for (int t = 0; t < 40; t++) begin
            a = $urandom; b = $urandom; c = $urandom;
            if (t % 4 == 0) b = b & 32'h000000FF;
            do_mul(a, b, 0, r1);
            chk("R1 random product", r1, ref_mul(a, b));
            do_mul(b, a, 0, r2);
            chk("R4 commutative", r2, r1);
            do_mul(a, c, 0, r2);
            do_mul(a, b ^ c, 0, r3);
            chk("R9 distributes over xor", r3, r1 ^ r2);
            do_mul(a, a, 0, r2);
            chk("R5 self product parity", r2, {31'd0, ^a});
            k = int'($urandom % 32);
            do_mul(a, 32'd1 << k, 0, r2);
            chk("R3 single-bit multiplier", r2, ref_perm(a, k));
        end
        summary();
    end
endmodule